// File: doc/BRIEF.md
# Time Slot Interchange Switching Core

This block moves byte-wide time slots between four serial receive lanes and four serial transmit lanes. Each lane carries a frame of 32 eight-bit channels, so the core is a 128 by 128 channel switch. Every received channel is assembled from the serial bits and stored in a data memory that has two banks. One bank fills during the current frame while the other, completed in the previous frame, is read. Switched data therefore leaves exactly one frame after it arrived, and no byte is ever read while it is half written.

For every transmit slot the core holds two connection entries. The low entry is an 8-bit word. It is either a source address (lane and channel) into the data memory, or a fixed byte to send. The high entry holds two flags: a constant-source flag and a driver-enable flag. A global processor-mode input forces every slot to send its low entry and to drive. An output-enable pin, when low, tri-states every lane at once, whatever the memory or the mode holds. Connection entries are fetched one channel ahead, so each transmit byte and its enable change together on the channel boundary. The connection memories are loaded through a plain write port.

Top module: `tsi_core`

## Requirements
- R1: After reset `tx_en` is all zeros. A `frame_sync` sampled high at a clock edge makes the next cycle bit position 0 (channel 0, bit 7). Bits are sent and received most significant bit first, 8 cycles per channel, and 256 cycles per frame with no further `frame_sync` needed.
- R2: When the slot's high-entry constant flag (write-data bit 2) is 0 and processor mode is off, the slot sends the byte received in the previous frame on lane `low[6:5]`, channel `low[4:0]`. Bit 7 of the low entry is ignored.
- R3: When the constant flag is 1, the slot sends the 8-bit low entry itself.
- R4: With `out_enable` high and processor mode off, the high-entry drive flag (write-data bit 0) sets that slot's `tx_en` bit: 1 drives, 0 disables. Write-data bits 7..3 and 1 of a high entry are ignored.
- R5: With `proc_mode` high, every slot sends its low entry and drives, whatever the high entries hold.
- R6: While `out_enable` is low, `tx_en` is all zeros in the same cycle, whatever the memories or the mode.
- R7: A lane's `tx_en` bit changes only on a channel boundary, unless `out_enable` changes.
- R8: Received data is double-buffered per frame. A byte received in frame F is sent in frame F+1, even when channel 31 is switched to channel 0.
- R9: A write on the configuration port (`cfg_hi` = 1 selects the high entry) at lane `cfg_strm` and channel `cfg_chan` governs that slot from the next frame onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one bit per lane per cycle |
| rst | input | 1 | Synchronous active-high reset |
| frame_sync | input | 1 | Frame alignment; the next cycle is channel 0, bit 7 |
| rx_data | input | 4 | Serial receive bit, one per lane |
| out_enable | input | 1 | Low tri-states all transmit lanes |
| proc_mode | input | 1 | Forces all slots to constant and driving |
| cfg_we | input | 1 | Connection memory write strobe |
| cfg_hi | input | 1 | 1 selects the high entry, 0 the low entry |
| cfg_strm | input | 2 | Transmit lane of the written slot |
| cfg_chan | input | 5 | Channel of the written slot |
| cfg_wdata | input | 8 | Write data |
| tx_data | output | 4 | Serial transmit bit, one per lane |
| tx_en | output | 4 | Per-lane driver enable for the current bit |

## Verification
A wrong bit position or a wrong bank index shows as wrong bits in the very first switched slot of the following frame. A bank that fails to swap delivers data two frames old, or data from the frame still being filled. A connection entry that is fetched late or read from the wrong slot shows up within one channel, as a wrong byte or an enable that flips in mid-slot. A missed bypass on the channel-31-to-channel-0 path shows in the first slot of every frame. The bench predicts every bit and enable on every cycle, so any of these faults is seen within one frame.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    localparam int unsigned N_STRM  = 4;
    localparam int unsigned N_CHAN  = 32;
    localparam int unsigned SLOT_W  = 8;
    localparam int unsigned STRM_W  = $clog2(N_STRM);
    localparam int unsigned CHAN_W  = $clog2(N_CHAN);
    localparam int unsigned BIT_W   = $clog2(SLOT_W);
    localparam int unsigned POS_W   = CHAN_W + BIT_W;
    localparam int unsigned CONST_BIT = 2;
    localparam int unsigned DRIVE_BIT = 0;

    typedef logic [SLOT_W-1:0] slot_t;
    typedef logic [STRM_W-1:0] strm_t;
    typedef logic [CHAN_W-1:0] chan_t;
    typedef logic [POS_W-1:0]  pos_t;

    typedef struct packed {
        logic is_const;
        logic drive;
    } slot_ctl_t;

    typedef struct packed {
        strm_t strm;
        chan_t chan;
    } src_addr_t;

    function automatic src_addr_t decode_src(slot_t v);
        src_addr_t a;
        a.strm = v[CHAN_W+STRM_W-1:CHAN_W];
        a.chan = v[CHAN_W-1:0];
        return a;
    endfunction

    function automatic slot_ctl_t decode_ctl(slot_ctl_t raw, logic force_all);
        slot_ctl_t c;
        c.is_const = raw.is_const | force_all;
        c.drive    = raw.drive | force_all;
        return c;
    endfunction
endpackage

// File: rtl/tsi_frame_timer.sv
module tsi_frame_timer import tsi_pkg::*; (
    input  logic clk,
    input  logic rst,
    input  logic frame_sync,
    output pos_t pos,
    output logic wr_bank,
    output logic slot_end,
    output logic frame_end
);
    assign slot_end  = &pos[BIT_W-1:0];
    assign frame_end = &pos;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos     <= '1;
            wr_bank <= 1'b0;
        end else begin
            pos <= frame_sync ? '0 : pos_t'(pos + 1'b1);
            if (frame_end)
                wr_bank <= ~wr_bank;
        end
    end
endmodule

// File: rtl/tsi_rx_capture.sv
module tsi_rx_capture import tsi_pkg::*; (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [N_STRM-1:0]            rx_bits,
    input  pos_t                         pos,
    input  logic                         slot_end,
    input  logic                         frame_end,
    input  logic                         wr_bank,
    input  src_addr_t [N_STRM-1:0]       rd_addr,
    output slot_t     [N_STRM-1:0]       rd_data
);
    slot_t shreg    [N_STRM];
    slot_t incoming [N_STRM];
    slot_t dmem     [2][N_STRM][N_CHAN];
    chan_t wr_chan;
    logic  rd_bank;

    assign wr_chan = pos[POS_W-1:BIT_W];
    // the bank completed last frame; at the frame edge the filling bank is about to become it
    assign rd_bank = frame_end ? wr_bank : ~wr_bank;

    for (genvar s = 0; s < N_STRM; s++) begin : g_in
        assign incoming[s] = {shreg[s][SLOT_W-2:0], rx_bits[s]};

        always_ff @(posedge clk) begin
            if (rst) shreg[s] <= '0;
            else     shreg[s] <= incoming[s];
        end

        always_ff @(posedge clk) begin
            if (!rst && slot_end)
                dmem[wr_bank][s][wr_chan] <= incoming[s];
        end
    end

    for (genvar o = 0; o < N_STRM; o++) begin : g_rd
        // last channel lands on the same edge it is fetched: forward it
        assign rd_data[o] = (frame_end && (&rd_addr[o].chan))
                          ? incoming[rd_addr[o].strm]
                          : dmem[rd_bank][rd_addr[o].strm][rd_addr[o].chan];
    end
endmodule

// File: rtl/tsi_conn_mem.sv
module tsi_conn_mem import tsi_pkg::*; (
    input  logic                    clk,
    input  logic                    we,
    input  logic                    hi,
    input  strm_t                   wstrm,
    input  chan_t                   wchan,
    input  slot_t                   wdata,
    input  chan_t                   rchan,
    output slot_t     [N_STRM-1:0]  low_q,
    output slot_ctl_t [N_STRM-1:0]  high_q
);
    slot_t     low_mem  [N_STRM][N_CHAN];
    slot_ctl_t high_mem [N_STRM][N_CHAN];

    always_ff @(posedge clk) begin
        if (we) begin
            if (hi) high_mem[wstrm][wchan] <= '{is_const: wdata[CONST_BIT], drive: wdata[DRIVE_BIT]};
            else    low_mem[wstrm][wchan]  <= wdata;
        end
    end

    for (genvar s = 0; s < N_STRM; s++) begin : g_rd
        assign low_q[s]  = low_mem[s][rchan];
        assign high_q[s] = high_mem[s][rchan];
    end
endmodule

// File: rtl/tsi_tx_lane.sv
module tsi_tx_lane import tsi_pkg::*; (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  slot_t load_byte,
    input  logic  load_drive,
    output logic  ser,
    output logic  drive
);
    slot_t shreg;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg <= '0;
            drive <= 1'b0;
        end else if (load) begin
            shreg <= load_byte;
            drive <= load_drive;
        end else begin
            shreg <= {shreg[SLOT_W-2:0], 1'b0};
        end
    end

    assign ser = shreg[SLOT_W-1];
endmodule

// File: rtl/tsi_core.sv
module tsi_core import tsi_pkg::*; (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_sync,
    input  logic [N_STRM-1:0] rx_data,
    input  logic              out_enable,
    input  logic              proc_mode,
    input  logic              cfg_we,
    input  logic              cfg_hi,
    input  logic [STRM_W-1:0] cfg_strm,
    input  logic [CHAN_W-1:0] cfg_chan,
    input  logic [SLOT_W-1:0] cfg_wdata,
    output logic [N_STRM-1:0] tx_data,
    output logic [N_STRM-1:0] tx_en
);
    pos_t  pos;
    logic  wr_bank, slot_end, frame_end;
    chan_t next_chan;

    slot_t     [N_STRM-1:0] cml_rd;
    slot_ctl_t [N_STRM-1:0] cmh_rd;
    src_addr_t [N_STRM-1:0] rd_addr;
    slot_t     [N_STRM-1:0] rd_data;
    logic      [N_STRM-1:0] lane_drive;

    tsi_frame_timer u_timer (
        .clk(clk), .rst(rst), .frame_sync(frame_sync),
        .pos(pos), .wr_bank(wr_bank), .slot_end(slot_end), .frame_end(frame_end)
    );

    // fetch for the channel that starts after this one
    assign next_chan = chan_t'(pos[POS_W-1:BIT_W] + 1'b1);

    tsi_conn_mem u_conn (
        .clk(clk), .we(cfg_we), .hi(cfg_hi), .wstrm(cfg_strm), .wchan(cfg_chan),
        .wdata(cfg_wdata), .rchan(next_chan), .low_q(cml_rd), .high_q(cmh_rd)
    );

    tsi_rx_capture u_rx (
        .clk(clk), .rst(rst), .rx_bits(rx_data), .pos(pos), .slot_end(slot_end),
        .frame_end(frame_end), .wr_bank(wr_bank), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    for (genvar s = 0; s < N_STRM; s++) begin : g_lane
        slot_ctl_t ctl;
        slot_t     pick;

        assign ctl        = decode_ctl(cmh_rd[s], proc_mode);
        assign rd_addr[s] = decode_src(cml_rd[s]);
        assign pick       = ctl.is_const ? cml_rd[s] : rd_data[s];

        tsi_tx_lane u_lane (
            .clk(clk), .rst(rst), .load(slot_end), .load_byte(pick),
            .load_drive(ctl.drive), .ser(tx_data[s]), .drive(lane_drive[s])
        );
    end

    assign tx_en = lane_drive & {N_STRM{out_enable}};
endmodule

// File: rtl/tsi_core_checker.sv
module tsi_core_checker import tsi_pkg::*; (
    input logic              clk,
    input logic              rst,
    input logic              frame_sync,
    input logic              out_enable,
    input logic              proc_mode,
    input logic [N_STRM-1:0] tx_en,
    input pos_t              pos,
    input logic              wr_bank
);
    assert_hiz_pin_R6: assert property (@(posedge clk) disable iff (rst)
        !out_enable |-> (tx_en == '0));

    assert_pos_step_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(frame_sync)) |-> (pos == pos_t'($past(pos) + 1'b1)));

    assert_sync_zero_R1: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(frame_sync)) |-> (pos == '0));

    assert_bank_swap_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (&$past(pos))) |-> (wr_bank != $past(wr_bank)));

    assert_bank_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !(&$past(pos))) |-> $stable(wr_bank));

    assert_en_boundary_R7: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && out_enable && $past(out_enable) && !(&$past(pos[BIT_W-1:0])))
        |-> $stable(tx_en));

    assert_proc_drive_R5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(proc_mode) && (&$past(pos[BIT_W-1:0])) && out_enable)
        |-> (tx_en == '1));
endmodule

bind tsi_core tsi_core_checker u_chk (
    .clk(clk), .rst(rst), .frame_sync(frame_sync), .out_enable(out_enable),
    .proc_mode(proc_mode), .tx_en(tx_en), .pos(pos), .wr_bank(wr_bank)
);

// File: tb/tsi_core_bench.sv
module tsi_core_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_sync = 1'b0;
    logic [3:0] rx_data = '0;
    logic       out_enable = 1'b0;
    logic       proc_mode = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_hi = 1'b0;
    logic [1:0] cfg_strm = '0;
    logic [4:0] cfg_chan = '0;
    logic [7:0] cfg_wdata = '0;
    logic [3:0] tx_data, tx_en;

    always #2 clk = ~clk;

    tsi_core u_tsi_core (
        .clk(clk), .rst(rst), .frame_sync(frame_sync), .rx_data(rx_data),
        .out_enable(out_enable), .proc_mode(proc_mode), .cfg_we(cfg_we), .cfg_hi(cfg_hi),
        .cfg_strm(cfg_strm), .cfg_chan(cfg_chan), .cfg_wdata(cfg_wdata),
        .tx_data(tx_data), .tx_en(tx_en)
    );

    int checks = 0;
    int errors = 0;
    int bpos = 255;
    int fr = -1;
    int valid_frame = 1000000;
    string phase_tag = "";
    logic [7:0] cml_m [4][32];
    logic [7:0] cmh_m [4][32];
    logic       proc_m = 1'b0;
    logic [3:0] prev_en = '0;
    logic       prev_pin = 1'b0;

    function automatic logic [7:0] gen(int f, int s, int c);
        int v;
        v = f * 29 + s * 83 + c * 11 + f * c * 3;
        return v[7:0] ^ 8'(s << 5);
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s frame %0d pos %0d: actual %0h expected %0h", tag, fr, bpos, act, exp);
        end
    endtask

    task automatic step();
        int c;
        int b;
        logic [7:0] v;
        c = bpos / 8;
        b = 7 - (bpos % 8);
        frame_sync = (bpos == 255);
        for (int s = 0; s < 4; s++) begin
            v = gen(fr, s, c);
            rx_data[s] = v[b];
        end
        @(negedge clk);
        for (int s = 0; s < 4; s++) begin
            logic cs, dr, e_en;
            logic [7:0] lo, byte_e;
            string tag;
            lo = cml_m[s][c];
            cs = proc_m | cmh_m[s][c][2];
            dr = proc_m | cmh_m[s][c][0];
            e_en = dr & out_enable;
            if (!out_enable) begin
                chk(tx_en[s] == 1'b0, "R6 pin low", int'(tx_en[s]), 0);
            end else if (fr >= valid_frame) begin
                tag = proc_m ? "R5 proc" : (cs ? "R3 const" : "R2 switched");
                chk(tx_en[s] == e_en, {"R4 enable ", tag, phase_tag}, int'(tx_en[s]), int'(e_en));
                if (e_en) begin
                    byte_e = cs ? lo : gen(fr - 1, int'(lo[6:5]), int'(lo[4:0]));
                    if (!cs && c == 0 && lo[4:0] == 5'd31) tag = "R8 ch31->ch0";
                    chk(tx_data[s] == byte_e[b], {tag, phase_tag}, int'(tx_data[s]), int'(byte_e[b]));
                end
            end
            if (fr >= 0 && out_enable && prev_pin && (bpos % 8) != 0)
                chk(tx_en[s] == prev_en[s], "R7 mid-slot enable", int'(tx_en[s]), int'(prev_en[s]));
        end
        prev_en = tx_en;
        prev_pin = out_enable;
        @(posedge clk);
        if (cfg_we) begin
            if (cfg_hi) cmh_m[cfg_strm][cfg_chan] = cfg_wdata;
            else        cml_m[cfg_strm][cfg_chan] = cfg_wdata;
            valid_frame = fr + 2;
        end
        bpos++;
        if (bpos == 256) begin
            bpos = 0;
            fr++;
        end
        #1;
    endtask

    task automatic wr_cfg(bit hi, int s, int c, logic [7:0] d);
        cfg_we = 1'b1;
        cfg_hi = hi;
        cfg_strm = 2'(s);
        cfg_chan = 5'(c);
        cfg_wdata = d;
        step();
        cfg_we = 1'b0;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int s = 0; s < 4; s++)
            for (int c = 0; c < 32; c++) begin
                cml_m[s][c] = '0;
                cmh_m[s][c] = '0;
            end
        out_enable = 1'b1;
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(tx_en == 4'b0, "R1 reset enables", int'(tx_en), 0);
        @(posedge clk);
        #1;
        rst = 1'b0;
        out_enable = 1'b0;
        // program every slot: all four flag combinations, ignored bits set
        for (int s = 0; s < 4; s++)
            for (int c = 0; c < 32; c++) begin
                logic [1:0] k;
                k = 2'(s + c);
                wr_cfg(1'b1, s, c, {5'(c * 3), k[1], 1'b1, k[0]});
                wr_cfg(1'b0, s, c, {c[0], 2'(s + 1), 5'(c * 7 + s + 31)});
            end
        out_enable = 1'b1;
        run(256 * 3);
        // pin low in mid frame, then restore
        run(100);
        out_enable = 1'b0;
        run(40);
        out_enable = 1'b1;
        run(256 * 2);
        // processor mode override
        proc_mode = 1'b1;
        proc_m = 1'b1;
        valid_frame = fr + 2;
        run(256 * 3);
        proc_mode = 1'b0;
        proc_m = 1'b0;
        valid_frame = fr + 2;
        run(256 * 2);
        // rewrite one lane: all constant, alternating drive
        phase_tag = " R9 rewrite";
        for (int c = 0; c < 32; c++) begin
            wr_cfg(1'b1, 2, c, c[0] ? 8'h05 : 8'h04);
            wr_cfg(1'b0, 2, c, 8'(c * 9 + 1));
        end
        run(256 * 3);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule